// File: doc/BRIEF.md
# Slice Display Sequencer with Overrun Recovery

This controller paces the delivery of one display slice, column by column, to a bank of LED drivers, keeping in step with a rotation position tick. After reset it does nothing until the upstream stream reports that enough image data is buffered. From then on it alternates between sending a slice and waiting for the next position tick. While sending, it moves one data word per clock whenever the drivers report that they can accept data. It presents the word, column and slice indices as a read address to the frame memory. When a column is complete it raises a one-cycle column pulse, which the column multiplexer uses to light that column.

A slice has a fixed number of columns. Once the last one is sent, the sequencer idles until a position tick arrives. The tick advances the slice index, which wraps at a parameterised slice count, and sending starts again. A tick can arrive while a slice is still being sent, either because the slice is too long or because the rotation runs fast. In that case the sequencer holds the tick in a pending flag and finishes the column in progress. It then drops the rest of that slice and starts the next slice from its first column. The extra delay this adds to the next slice is at most one column transfer.

Top module: `slice_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, `xfer_en` and `column_ready` are 0 and `word_idx`, `col_idx` and `slice_idx` are all 0.
- R2: Until `stream_ready` has been seen high on a clock edge, `xfer_en` stays 0 whatever `driver_ready` and `position_sync` do.
- R3: While sending, `xfer_en` equals `driver_ready`. Each cycle with `xfer_en` high transfers the word at `word_idx`, which then advances by one and wraps from WORDS_PER_COL-1 to 0. `word_idx` does not change in a cycle without a transfer.
- R4: `column_ready` is high for exactly the one cycle after the transfer of word WORDS_PER_COL-1 of a column, and at no other time.
- R5: When column COLUMNS-1 completes and no position tick is pending, the sequencer enters the wait state. In that state `xfer_en` is 0 even while `driver_ready` is high.
- R6: A `position_sync` pulse during the wait state starts sending in the next cycle, at slice index +1, column 0 and word 0.
- R7: A `position_sync` that arrives while a column is being sent lets that column finish. The next transfer is then word 0 of column 0 of slice index +1, and the rest of the old slice is skipped.
- R8: A single-cycle `position_sync` that arrives early in a column is held until that column ends and is then acted on as in R7.
- R9: `slice_idx` wraps from SLICES-1 to 0.
- R10: Several `position_sync` pulses within one column advance the slice by one only.
- R11: Once sending has started, dropping `stream_ready` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stream_ready | input | 1 | Upstream has buffered enough slices; starts the sequencer |
| position_sync | input | 1 | Single-cycle rotation position tick |
| driver_ready | input | 1 | Drivers can accept a word this cycle |
| xfer_en | output | 1 | A word is transferred this cycle |
| word_idx | output | clog2(WORDS_PER_COL) | Word index within the current column |
| col_idx | output | clog2(COLUMNS) | Current column index |
| slice_idx | output | clog2(SLICES) | Current slice index |
| column_ready | output | 1 | One-cycle pulse after a column completes |

## Verification
The checker watches several properties on every cycle. It confirms that a transfer only happens with the drivers ready and that the word index steps by one per transfer and is otherwise frozen. It confirms that the column pulse follows the final word of a column and never lasts two cycles, that the column index moves only at a column end, and that the slice index only ever steps by one with wraparound. Other behaviours depend on a history of inputs, and only the bench's scenarios can show them. These are the idle behaviour before start, entry into the wait state after the last column, and the dropping of a cut-off slice. The same applies to holding one early tick until the column ends and merging repeated ticks into a single step. The bench follows each of these against a cycle model under both directed and random stimulus.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;

    // Control strobes from the FSM to the index counters.
    typedef struct packed {
        logic word_inc;
        logic word_clr;
        logic col_inc;
        logic col_clr;
        logic slice_inc;
        logic slice_clr;
    } ctr_ctl_t;

    function automatic int ctr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seq_wrap_ctr.sv
module seq_wrap_ctr #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= (value == TOP) ? '0 : value + W'(1);
        end
    end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stream_ready,
    input  logic     position_sync,
    input  logic     driver_ready,
    input  logic     word_last,
    input  logic     col_last,
    output logic     xfer_en,
    output logic     column_ready,
    output ctr_ctl_t ctl
);
    seq_state_t state_q, state_d;
    logic       pend_q, pend_d;
    logic       start, col_end, sync_hit;

    assign start    = (state_q == SEQ_IDLE) && stream_ready;
    assign xfer_en  = (state_q == SEQ_SEND) && driver_ready;
    assign col_end  = xfer_en && word_last;
    assign sync_hit = pend_q || position_sync;

    always_comb begin
        state_d = state_q;
        pend_d  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: if (stream_ready) state_d = SEQ_SEND;
            SEQ_SEND: begin
                pend_d = sync_hit && !col_end;
                if (col_end && !sync_hit && col_last) state_d = SEQ_WAIT;
            end
            SEQ_WAIT: if (position_sync) state_d = SEQ_SEND;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        ctl.word_inc  = xfer_en;
        ctl.word_clr  = start;
        ctl.col_inc   = col_end && !sync_hit;
        ctl.col_clr   = start || (col_end && sync_hit);
        ctl.slice_clr = start;
        ctl.slice_inc = (col_end && sync_hit) ||
                        ((state_q == SEQ_WAIT) && position_sync);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SEQ_IDLE;
            pend_q       <= 1'b0;
            column_ready <= 1'b0;
        end else begin
            state_q      <= state_d;
            pend_q       <= pend_d;
            column_ready <= col_end;
        end
    end
endmodule

// File: rtl/slice_sequencer.sv
module slice_sequencer
    import seq_pkg::*;
#(
    parameter int COLUMNS       = 8,
    parameter int WORDS_PER_COL = 512,
    parameter int SLICES        = 128,
    localparam int WW = ctr_w(WORDS_PER_COL),
    localparam int CW = ctr_w(COLUMNS),
    localparam int SW = ctr_w(SLICES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stream_ready,
    input  logic          position_sync,
    input  logic          driver_ready,
    output logic          xfer_en,
    output logic [WW-1:0] word_idx,
    output logic [CW-1:0] col_idx,
    output logic [SW-1:0] slice_idx,
    output logic          column_ready
);
    localparam logic [WW-1:0] WORD_TOP = WW'(WORDS_PER_COL - 1);
    localparam logic [CW-1:0] COL_TOP  = CW'(COLUMNS - 1);

    ctr_ctl_t ctl;
    logic     word_last, col_last;

    assign word_last = (word_idx == WORD_TOP);
    assign col_last  = (col_idx == COL_TOP);

    seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .stream_ready (stream_ready),
        .position_sync(position_sync),
        .driver_ready (driver_ready),
        .word_last    (word_last),
        .col_last     (col_last),
        .xfer_en      (xfer_en),
        .column_ready (column_ready),
        .ctl          (ctl)
    );

    seq_wrap_ctr #(.N(WORDS_PER_COL), .W(WW)) u_word (
        .clk(clk), .rst(rst), .clr(ctl.word_clr), .inc(ctl.word_inc), .value(word_idx)
    );

    seq_wrap_ctr #(.N(COLUMNS), .W(CW)) u_col (
        .clk(clk), .rst(rst), .clr(ctl.col_clr), .inc(ctl.col_inc), .value(col_idx)
    );

    seq_wrap_ctr #(.N(SLICES), .W(SW)) u_slice (
        .clk(clk), .rst(rst), .clr(ctl.slice_clr), .inc(ctl.slice_inc), .value(slice_idx)
    );
endmodule

// File: rtl/slice_sequencer_chk.sv
module slice_sequencer_chk #(
    parameter int COLUMNS       = 8,
    parameter int WORDS_PER_COL = 512,
    parameter int SLICES        = 128,
    parameter int WW = 9,
    parameter int CW = 3,
    parameter int SW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          driver_ready,
    input logic          xfer_en,
    input logic [WW-1:0] word_idx,
    input logic [CW-1:0] col_idx,
    input logic [SW-1:0] slice_idx,
    input logic          column_ready
);
    localparam logic [WW-1:0] W_LAST = WW'(WORDS_PER_COL - 1);
    localparam logic [CW-1:0] C_LAST = CW'(COLUMNS - 1);
    localparam logic [SW-1:0] S_LAST = SW'(SLICES - 1);

    // R3: a transfer never happens without the drivers being ready
    a_r3_needs_ready: assert property (@(posedge clk) disable iff (rst)
        xfer_en |-> driver_ready);

    // R3: word index steps by one on a transfer that is not the column end
    a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && word_idx != W_LAST) |=> (word_idx == $past(word_idx) + WW'(1)));

    // R3: word index frozen without a transfer
    a_r3_word_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer_en |=> $stable(word_idx));

    // R4: column pulse only after the last word of a column
    a_r4_pulse_source: assert property (@(posedge clk) disable iff (rst)
        column_ready |-> $past(xfer_en && word_idx == W_LAST));

    // R4: column pulse lasts a single cycle
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (column_ready && WORDS_PER_COL > 1) |=> !column_ready);

    // R7: column index moves only at a column end
    a_r7_col_moves_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(col_idx) |-> $past(xfer_en && word_idx == W_LAST));

    // R5: column index stays within the slice
    a_r5_col_range: assert property (@(posedge clk) disable iff (rst)
        col_idx <= C_LAST);

    // R9, R10: slice index only ever steps by one, with wrap
    a_r9_slice_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(slice_idx) |->
            (slice_idx == (($past(slice_idx) == S_LAST) ? '0 : $past(slice_idx) + SW'(1))));
endmodule

bind slice_sequencer slice_sequencer_chk #(
    .COLUMNS(COLUMNS), .WORDS_PER_COL(WORDS_PER_COL), .SLICES(SLICES),
    .WW(WW), .CW(CW), .SW(SW)
) u_chk (
    .clk(clk), .rst(rst), .driver_ready(driver_ready), .xfer_en(xfer_en),
    .word_idx(word_idx), .col_idx(col_idx), .slice_idx(slice_idx),
    .column_ready(column_ready)
);

// File: tb/slice_sequencer_bench.sv
`timescale 1ns/1ps
module slice_sequencer_bench;
    localparam int C = 8;
    localparam int W = 6;
    localparam int S = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stream_ready = 1'b0;
    logic       position_sync = 1'b0;
    logic       driver_ready = 1'b0;
    logic       xfer_en, column_ready;
    logic [2:0] word_idx, col_idx, slice_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // cycle model state
    int m_st = 0;   // 0 idle, 1 send, 2 wait
    int m_word = 0, m_col = 0, m_slice = 0;
    bit m_pend = 0, m_cr = 0;

    always #4 clk = ~clk;

    slice_sequencer #(.COLUMNS(C), .WORDS_PER_COL(W), .SLICES(S)) u_slice_sequencer (
        .clk(clk), .rst(rst), .stream_ready(stream_ready),
        .position_sync(position_sync), .driver_ready(driver_ready),
        .xfer_en(xfer_en), .word_idx(word_idx), .col_idx(col_idx),
        .slice_idx(slice_idx), .column_ready(column_ready)
    );

    function automatic int nxt_slice(input int s);
        return (s == S - 1) ? 0 : s + 1;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick(input logic sr, input logic ps, input logic dr);
        bit x, cend, hit;
        @(negedge clk);
        stream_ready = sr; position_sync = ps; driver_ready = dr;
        #1;
        x = (m_st == 1) && dr;
        chk(m_st == 0 ? "R2 xfer_en" : "R3 xfer_en", int'(xfer_en), int'(x));
        chk("R3 word_idx", int'(word_idx), m_word);
        chk("R7 col_idx", int'(col_idx), m_col);
        chk("R6 slice_idx", int'(slice_idx), m_slice);
        chk("R4 column_ready", int'(column_ready), int'(m_cr));
        cend = x && (m_word == W - 1);
        hit  = m_pend || ps;
        m_cr = cend;
        case (m_st)
            0: if (sr) begin m_st = 1; m_word = 0; m_col = 0; m_slice = 0; end
            1: begin
                if (x) m_word = cend ? 0 : m_word + 1;
                m_pend = hit && !cend;
                if (cend) begin
                    if (hit) begin m_col = 0; m_slice = nxt_slice(m_slice); end
                    else if (m_col == C - 1) begin m_col = 0; m_st = 2; end
                    else m_col = m_col + 1;
                end
            end
            default: if (ps) begin m_st = 1; m_slice = nxt_slice(m_slice); end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_1D55));
        repeat (3) @(negedge clk);
        driver_ready = 1'b1;
        #1;
        chk("R1 xfer_en in reset", int'(xfer_en), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 xfer_en", int'(xfer_en), 0);
        chk("R1 column_ready", int'(column_ready), 0);
        chk("R1 indices", int'(word_idx) + int'(col_idx) + int'(slice_idx), 0);

        // R2: idle with drivers ready and a stray tick
        repeat (5) tick(0, 0, 1);
        tick(0, 1, 1);
        repeat (4) tick(0, 0, 1);
        chk("R2 idle no transfer", int'(xfer_en), 0);

        // R11: one-cycle start, then stream_ready dropped
        tick(1, 0, 1);
        tick(0, 0, 1);
        chk("R11 running after drop", int'(xfer_en), 1);
        repeat (C * W - 1) tick(0, 0, 1);
        tick(0, 0, 1);
        chk("R5 wait after last column", int'(xfer_en), 0);
        chk("R4 pulse after last column", int'(column_ready), 1);
        repeat (9) tick(0, 0, 1);
        chk("R5 still waiting", int'(xfer_en), 0);
        chk("R4 pulse gone", int'(column_ready), 0);

        // R6: tick in wait
        tick(0, 1, 1);
        tick(0, 0, 1);
        chk("R6 resume xfer", int'(xfer_en), 1);
        chk("R6 slice advanced", int'(slice_idx), 1);
        chk("R6 column zero", int'(col_idx), 0);

        // R8, R10: early tick then a second one within the column
        tick(0, 0, 1);
        tick(0, 1, 1);
        tick(0, 1, 1);
        tick(0, 0, 1);
        tick(0, 0, 1);
        tick(0, 0, 1);
        chk("R7 column restart", int'(col_idx), 0);
        chk("R7 word restart", int'(word_idx), 0);
        chk("R10 single slice step", int'(slice_idx), 2);
        chk("R8 pulse at cut column", int'(column_ready), 1);

        // R9: cut slices until the index wraps
        for (int k = 0; k < 3; k++) begin
            tick(0, 1, 1);
            repeat (W - 2) tick(0, 0, 1);
            tick(0, 0, 1);
        end
        chk("R9 slice wrap", int'(slice_idx), 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            tick(($urandom % 8) == 0, ($urandom % 45) == 0, ($urandom % 4) != 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule